// File: doc/BRIEF.md
# Debug Control Register Port

This block is a small set of memory-mapped debug registers behind an APB3 slave port. An external debugger or the processor side reads and writes them with 32-bit data. An extra address bit on each transfer marks which of the two started it. Every transfer takes one wait state. A transfer to an unmapped word, or a processor-side transfer to a debugger-only register, ends with an error response.

The block also runs the external halt handshake. A system agent raises `halt_req` and must hold it until `halt_ack` rises. The core reports that it has entered debug state on `core_halted`. The block then raises `halt_ack` and records why debug state was entered. If the request is dropped too early, the block sets a sticky flag instead of leaving the outcome undefined. Software can also force `halt_ack` high through a control bit.

Two more registers complete the set. A power control bit drives `no_pwrdn`. A read-only register returns the tied-off debug ROM base address and its valid flag.

Top module: `dbg_apb_regs`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `pready`, `pslverr`, `prdata`, `halt_ack` and `no_pwrdn` are all 0. The status register and the power register both read 0.
- R2: In every transfer, `pready` is low in the first access-phase cycle (`psel` and `penable` high) and high in the second, so there is exactly one wait state.
- R3: Word index 0x000 (byte 0x000) is the ROM base register. It reads `{rom_base[19:0], 10'b0, rom_ok, rom_ok}`, so bits [1:0] are 2'b11 when valid and 2'b00 when not. It is read-only: writes complete without error and change nothing.
- R4: A transfer to an unmapped word index completes with `pslverr` high and `prdata` zero. A write to an unmapped word changes no register.
- R5: Word index 0x0C4 (byte 0x310) is the power register; bit 0 is read/write and `no_pwrdn` follows it from the cycle after the write completes. Access to it with `paddr_dbg` = 0 (processor side) gets `pslverr` and reads zero, and a write from that side has no effect.
- R6: Word index 0x022 (byte 0x088) is the status register. Bit 10 is read/write and forces `halt_ack` high from the cycle after the write. Bits [31:11], [9:7] and [1] always read 0, whatever value was written.
- R7: Status bit 0 reads 1 while the core is in debug state. `halt_ack` rises one clock after `core_halted` rises and falls one clock after it falls, unless bit 10 holds it high.
- R8: On entry to debug state (rising `core_halted`), status bits [5:2] are loaded with 4'b0100 if `halt_req` is high, else with 4'b0000. The field keeps its value until the next entry.
- R9: If `halt_req` falls while `halt_ack` is low, status bit 6 is set one clock later and stays set. Writing 1 to bit 6 clears it; writing 0 leaves it unchanged.
- R10: If `halt_req` falls while `halt_ack` is high, status bit 6 is not set.
- R11: The status register and the ROM register accept transfers from both sides (`paddr_dbg` 0 or 1) without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 10 | APB word address, bits [11:2] |
| paddr_dbg | input | 1 | Access origin: 1 external debugger, 0 processor side |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the completing cycle |
| pready | output | 1 | APB ready, low in the first access cycle |
| pslverr | output | 1 | APB error response |
| halt_req | input | 1 | External request to enter debug state |
| core_halted | input | 1 | Core reports that it is in debug state |
| halt_ack | output | 1 | Debug acknowledge |
| no_pwrdn | output | 1 | Keep-powered request from the power register |
| rom_base | input | 20 | Debug ROM base address bits [31:12] (tie-off) |
| rom_ok | input | 1 | ROM base address valid (tie-off) |

## Verification
A transfer is driven as one setup cycle and then access cycles. The response (`pready` high with `prdata` and `pslverr`) is due in the third cycle of the transfer, and the write takes effect at the end of that cycle. A monitor samples on falling edges, counts the low-`pready` cycles before each completion, and compares the completion against the next item that the driver queued. `halt_ack` is checked one and two falling edges after `core_halted` changes: it must still be low at the first and high at the second. `no_pwrdn`, a forced `halt_ack` and the sticky drop flag are checked at the first falling edge after the write completes or after the request drops.

// File: rtl/dbg_apb_pkg.sv
// Package: shared constants and types for the debug register port.
// Assumes a 10-bit word address (byte address bits [11:2]).
package dbg_apb_pkg;
    localparam int ADDR_W = 10;

    // Word indices of the mapped registers
    localparam logic [ADDR_W-1:0] IDX_ROM  = 10'h000;
    localparam logic [ADDR_W-1:0] IDX_STAT = 10'h022;
    localparam logic [ADDR_W-1:0] IDX_PWR  = 10'h0C4;

    // Status register field positions
    localparam int ST_INDBG = 0;
    localparam int ST_RSN_LO = 2;
    localparam int ST_DROP = 6;
    localparam int ST_FORCE = 10;

    localparam int RSN_W = 4;
    localparam logic [RSN_W-1:0] RSN_EXT_REQ = 4'b0100;
    localparam logic [RSN_W-1:0] RSN_OTHER = 4'b0000;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ROM,
        SEL_STAT,
        SEL_PWR
    } reg_sel_e;
endpackage

// File: rtl/dbg_apb_port.sv
// Module: APB3 transfer timing and address decode.
// Inserts exactly one wait state per transfer and produces the error response.
// It also produces the strobes that commit writes and enable read data.
// Assumes the master holds psel/penable/paddr/pwrite stable until pready.
module dbg_apb_port
    import dbg_apb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              paddr_dbg,
    output logic              pready,
    output logic              pslverr,
    output reg_sel_e          sel,
    output logic              wr_stb,
    output logic              rd_stb
);
    logic waited_q;
    logic access;
    logic bad;

    assign access = psel && penable;

    // Wait-state flag: set after the first access cycle, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waited_q <= 1'b0;
        end else if (access && !waited_q) begin
            waited_q <= 1'b1;
        end else begin
            waited_q <= 1'b0;
        end
    end

    // Address decode to a register select
    always_comb begin
        case (paddr)
            IDX_ROM:  sel = SEL_ROM;
            IDX_STAT: sel = SEL_STAT;
            IDX_PWR:  sel = SEL_PWR;
            default:  sel = SEL_NONE;
        endcase
    end

    // Error when unmapped, or when the debugger-only register is hit from the processor side
    assign bad = (sel == SEL_NONE) || ((sel == SEL_PWR) && !paddr_dbg);

    assign pready  = access && waited_q;
    assign pslverr = pready && bad;
    assign wr_stb  = pready && pwrite && !bad;
    assign rd_stb  = pready && !pwrite && !bad;

    // R2: ready only after one wait cycle in the access phase
    a_r2_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> $past(access && !pready));

    // R2: a waiting access completes in the next cycle
    a_r2_wait_once: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !pready) |=> (pready || !access));
endmodule

// File: rtl/dbg_halt_hs.sv
// Module: halt request / acknowledge handshake.
// Registers the core's debug-state report and drives the acknowledge.
// Records the entry reason and flags a request dropped before it was acknowledged.
// Assumes core_halted and halt_req are synchronous to clk.
module dbg_halt_hs
    import dbg_apb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             core_halted,
    input  logic             force_ack,
    input  logic             drop_clr,
    output logic             halt_ack,
    output logic             in_dbg,
    output logic [RSN_W-1:0] reason,
    output logic             drop_err
);
    logic in_dbg_q;
    logic req_q;
    logic [RSN_W-1:0] rsn_q;
    logic drop_q;

    // Track the debug state and the previous request level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_dbg_q <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            in_dbg_q <= core_halted;
            req_q    <= halt_req;
        end
    end

    // Load the entry reason on each entry to debug state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsn_q <= '0;
        end else if (core_halted && !in_dbg_q) begin
            rsn_q <= halt_req ? RSN_EXT_REQ : RSN_OTHER;
        end
    end

    // Sticky flag for a request withdrawn before the acknowledge; setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (req_q && !halt_req && !halt_ack) begin
            drop_q <= 1'b1;
        end else if (drop_clr) begin
            drop_q <= 1'b0;
        end
    end

    assign halt_ack = in_dbg_q || force_ack;
    assign in_dbg   = in_dbg_q;
    assign reason   = rsn_q;
    assign drop_err = drop_q;

    // R7: acknowledge follows entry by one clock
    a_r7_ack_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_halted) |=> halt_ack);

    // R8: request-caused entry records the fixed code
    a_r8_reason_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_halted) && halt_req) |=> (reason == RSN_EXT_REQ));

    // R9: the sticky flag only rises after an unacknowledged request fell
    a_r9_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drop_err) |-> ($past(!halt_ack && !halt_req) && $past(halt_req, 2)));

    // R10: an acknowledged drop does not raise the flag
    a_r10_ack_drop_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(halt_req) && halt_ack && !drop_err) |=> !drop_err);
endmodule

// File: rtl/dbg_regs.sv
// Module: register storage and read-data mux.
// Holds the force-acknowledge and power bits, and builds each register's read value.
// Read data is zero unless a valid read completes.
// Assumes rom_base/rom_ok are static tie-offs.
module dbg_regs
    import dbg_apb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ROM_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROM_W-1:0]  rom_base,
    input  logic              rom_ok,
    input  logic              in_dbg,
    input  logic [RSN_W-1:0]  reason,
    input  logic              drop_err,
    output logic              force_ack,
    output logic              no_pwrdn,
    output logic              drop_clr,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - ROM_W - 2;

    logic force_q;
    logic pwr_q;
    logic [DATA_W-1:0] rom_v;
    logic [DATA_W-1:0] stat_v;
    logic [DATA_W-1:0] pwr_v;

    // Writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= 1'b0;
            pwr_q   <= 1'b0;
        end else if (wr_stb) begin
            if (sel == SEL_STAT) force_q <= wdata[ST_FORCE];
            if (sel == SEL_PWR)  pwr_q   <= wdata[0];
        end
    end

    assign drop_clr  = wr_stb && (sel == SEL_STAT) && wdata[ST_DROP];
    assign force_ack = force_q;
    assign no_pwrdn  = pwr_q;

    // ROM register layout depends on whether padding bits remain
    generate
        if (PAD_W > 0) begin : g_rom_pad
            assign rom_v = {rom_base, {PAD_W{1'b0}}, rom_ok, rom_ok};
        end else begin : g_rom_nopad
            assign rom_v = {rom_base, rom_ok, rom_ok};
        end
    endgenerate

    // Status register image
    always_comb begin
        stat_v = '0;
        stat_v[ST_INDBG] = in_dbg;
        stat_v[ST_RSN_LO +: RSN_W] = reason;
        stat_v[ST_DROP] = drop_err;
        stat_v[ST_FORCE] = force_q;
    end

    // Power register image
    always_comb begin
        pwr_v = '0;
        pwr_v[0] = pwr_q;
    end

    // Read-data mux, zero outside valid reads
    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            case (sel)
                SEL_ROM:  rdata = rom_v;
                SEL_STAT: rdata = stat_v;
                SEL_PWR:  rdata = pwr_v;
                default:  rdata = '0;
            endcase
        end
    end

    // R5: the power output takes the written bit
    a_r5_pwr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == SEL_PWR) |=> (no_pwrdn == $past(wdata[0])));

    // R6: the force bit takes the written bit
    a_r6_force_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == SEL_STAT) |=> (force_ack == $past(wdata[ST_FORCE])));
endmodule

// File: rtl/dbg_apb_regs.sv
// Module: top of the debug register port.
// Joins APB timing/decode, register storage and the halt handshake.
// Assumes one clock domain and a synchronous active-low reset.
module dbg_apb_regs
    import dbg_apb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ROM_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [11:2]       paddr,
    input  logic              paddr_dbg,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              halt_req,
    input  logic              core_halted,
    output logic              halt_ack,
    output logic              no_pwrdn,
    input  logic [ROM_W-1:0]  rom_base,
    input  logic              rom_ok
);
    reg_sel_e         sel;
    logic             wr_stb;
    logic             rd_stb;
    logic             force_ack;
    logic             drop_clr;
    logic             in_dbg;
    logic [RSN_W-1:0] reason;
    logic             drop_err;

    dbg_apb_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .paddr_dbg (paddr_dbg),
        .pready    (pready),
        .pslverr   (pslverr),
        .sel       (sel),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb)
    );

    dbg_regs #(.DATA_W(DATA_W), .ROM_W(ROM_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .wdata     (pwdata),
        .rom_base  (rom_base),
        .rom_ok    (rom_ok),
        .in_dbg    (in_dbg),
        .reason    (reason),
        .drop_err  (drop_err),
        .force_ack (force_ack),
        .no_pwrdn  (no_pwrdn),
        .drop_clr  (drop_clr),
        .rdata     (prdata)
    );

    dbg_halt_hs u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .core_halted (core_halted),
        .force_ack   (force_ack),
        .drop_clr    (drop_clr),
        .halt_ack    (halt_ack),
        .in_dbg      (in_dbg),
        .reason      (reason),
        .drop_err    (drop_err)
    );

    // R4: an error response carries zero data and completes the transfer
    a_r4_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (pready && prdata == '0));
endmodule

// File: tb/test_dbg_apb_regs.sv
// Scoreboard bench: the driver queues the expected completion of each transfer.
// The monitor compares every completion against the queue at falling edges.
module test_dbg_apb_regs;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:2] paddr = '0;
    logic        paddr_dbg = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        halt_req = 1'b0;
    logic        core_halted = 1'b0;
    logic        halt_ack;
    logic        no_pwrdn;
    logic [19:0] rom_base = 20'hABCDE;
    logic        rom_ok = 1'b1;

    int checks = 0;
    int fails = 0;
    int waits = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        bit          has_data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [11:2] W_ROM  = 10'h000;
    localparam logic [11:2] W_STAT = 10'h022;
    localparam logic [11:2] W_PWR  = 10'h0C4;
    localparam logic [11:2] W_BAD1 = 10'h001;
    localparam logic [11:2] W_BAD2 = 10'h023;

    dbg_apb_regs i_dbg_apb_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .paddr_dbg(paddr_dbg), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .halt_req(halt_req),
        .core_halted(core_halted), .halt_ack(halt_ack), .no_pwrdn(no_pwrdn),
        .rom_base(rom_base), .rom_ok(rom_ok)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Driver: queue the expectation, then run setup and access phases
    task automatic xfer(input bit wr, input logic [11:2] idx, input bit dbg,
                        input logic [31:0] wd, input logic [31:0] exp_d,
                        input bit exp_e, input string tag);
        exp_t e;
        e.data = exp_d;
        e.err = exp_e;
        e.has_data = !wr;
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = idx;
        paddr_dbg = dbg; pwdata = wd;
        @(posedge clk); #1;
        penable = 1'b1;
        do @(negedge clk); while (!pready);
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Monitor: count wait cycles and compare each completion with the queue
    always @(negedge clk) begin
        if (rst_n && psel && penable) begin
            if (!pready) begin
                waits++;
            end else begin
                exp_t e;
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected completion", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    check(waits == 1, {"R2 wait count ", e.tag}, waits, 32'd1);
                    if (e.has_data)
                        check(prdata == e.data, {e.tag, " data"}, prdata, e.data);
                    check(pslverr == e.err, {e.tag, " error"}, {31'd0, pslverr},
                          {31'd0, e.err});
                end
                waits = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_NS * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pready && !pslverr, "R1 reset handshake", {pready, pslverr}, 32'd0);
        check(prdata == 0, "R1 reset rdata", prdata, 32'd0);
        check(!halt_ack && !no_pwrdn, "R1 reset outputs", {halt_ack, no_pwrdn}, 32'd0);
        xfer(0, W_STAT, 1, 0, 32'h0, 0, "R1 status reset");
        xfer(0, W_PWR, 1, 0, 32'h0, 0, "R1 power reset");

        // R3 ROM register, then R11 access from the processor side
        xfer(0, W_ROM, 1, 0, 32'hABCDE003, 0, "R3 rom valid");
        xfer(1, W_ROM, 1, 32'h12345678, 0, 0, "R3 rom write ignored");
        xfer(0, W_ROM, 0, 0, 32'hABCDE003, 0, "R11 rom processor read");
        rom_base = 20'h0; rom_ok = 1'b0;
        xfer(0, W_ROM, 1, 0, 32'h0, 0, "R3 rom invalid");

        // R4 unmapped words
        xfer(0, W_BAD1, 1, 0, 32'h0, 1, "R4 unmapped read");
        xfer(1, W_BAD2, 1, 32'hFFFFFFFF, 0, 1, "R4 unmapped write");
        xfer(0, W_STAT, 1, 0, 32'h0, 0, "R4 status unchanged");

        // R5 power register
        xfer(1, W_PWR, 1, 32'h1, 0, 0, "R5 power set");
        @(negedge clk);
        check(no_pwrdn == 1'b1, "R5 no_pwrdn set", no_pwrdn, 32'd1);
        xfer(0, W_PWR, 1, 0, 32'h1, 0, "R5 power readback");
        xfer(1, W_PWR, 0, 32'h0, 0, 1, "R5 processor write");
        @(negedge clk);
        check(no_pwrdn == 1'b1, "R5 processor write ignored", no_pwrdn, 32'd1);
        xfer(0, W_PWR, 0, 0, 32'h0, 1, "R5 processor read");
        xfer(1, W_PWR, 1, 32'h0, 0, 0, "R5 power clear");
        @(negedge clk);
        check(no_pwrdn == 1'b0, "R5 no_pwrdn clear", no_pwrdn, 32'd0);

        // R6 force acknowledge, written from the processor side (R11)
        xfer(1, W_STAT, 0, 32'hFFFFFFFF, 0, 0, "R11 status processor write");
        @(negedge clk);
        check(halt_ack == 1'b1, "R6 forced ack", halt_ack, 32'd1);
        xfer(0, W_STAT, 0, 0, 32'h400, 0, "R6 reserved bits zero");
        xfer(1, W_STAT, 1, 32'h0, 0, 0, "R6 force clear");
        @(negedge clk);
        check(halt_ack == 1'b0, "R6 ack released", halt_ack, 32'd0);

        // R9 request dropped before acknowledge
        @(posedge clk); #1; halt_req = 1'b1;
        @(posedge clk); #1; halt_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(halt_ack == 1'b0, "R9 no ack on drop", halt_ack, 32'd0);
        xfer(0, W_STAT, 1, 0, 32'h40, 0, "R9 sticky set");
        xfer(1, W_STAT, 1, 32'h0, 0, 0, "R9 write zero");
        xfer(0, W_STAT, 1, 0, 32'h40, 0, "R9 sticky kept");
        xfer(1, W_STAT, 1, 32'h40, 0, 0, "R9 write one");
        xfer(0, W_STAT, 1, 0, 32'h0, 0, "R9 sticky cleared");

        // R7/R8 entry caused by the request
        @(posedge clk); #1; halt_req = 1'b1;
        idle(2);
        core_halted = 1'b1;
        @(negedge clk);
        check(halt_ack == 1'b0, "R7 ack not yet", halt_ack, 32'd0);
        @(negedge clk);
        check(halt_ack == 1'b1, "R7 ack one clock later", halt_ack, 32'd1);
        xfer(0, W_STAT, 1, 0, 32'h11, 0, "R8 reason external");

        // R10 acknowledged drop is clean
        @(posedge clk); #1; halt_req = 1'b0;
        idle(2);
        xfer(0, W_STAT, 1, 0, 32'h11, 0, "R10 no sticky");

        // R7 leave debug state, reason kept (R8)
        core_halted = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(halt_ack == 1'b0, "R7 ack falls", halt_ack, 32'd0);
        xfer(0, W_STAT, 1, 0, 32'h10, 0, "R8 reason kept");

        // R8 entry without a request
        @(posedge clk); #1; core_halted = 1'b1;
        idle(2);
        xfer(0, W_STAT, 1, 0, 32'h01, 0, "R8 reason other");

        idle(3);
        check(sb.size() == 0, "R2 all completions seen", sb.size(), 32'd0);
        report();
    end
endmodule